// File: doc/BRIEF.md
# Four-Level Symbol Mapper and Tenfold Interpolator

This block converts a stream of channel bytes into baseband samples for a four-level FSK modulator. Each accepted byte is cut into four two-bit symbols, starting with the most significant pair. Each symbol is mapped to a signed 16-bit amplitude. The symbol stream is then raised to ten samples per symbol by a polyphase FIR interpolator. The filter prototype is a 90-tap square-root raised cosine with a roll-off of 0.2, and its coefficients sit in a constant ROM inside the block. Each byte therefore yields 40 signed Q15 samples, one per clock.

The upstream logic offers bytes through a valid/ready handshake. Each byte carries a small marker code. The block places that marker on one chosen sample of the byte's 40-sample group, and every other sample carries the null marker. The filter's symbol history is kept between bytes, so the waveform stays continuous across bytes. This holds when bytes arrive back to back and also when there are idle gaps between them.

Top module: `fsk4Interp`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, `outSample` and `outMark` are 0, and every stored past symbol is zero.
- R2: The symbols of a byte are taken from bits [7:6] first, then [5:4], then [3:2], and last [1:0].
- R3: The amplitude of each symbol is set by its two-bit code: 2'b11 gives +1362, 2'b10 gives +454, 2'b00 gives -454, and 2'b01 gives -1362.
- R4: Each accepted byte produces exactly 40 samples, with `outValid` high on 40 consecutive cycles. The first of these cycles is the cycle right after the byte is accepted. `outValid` stays low when there is no byte to send.
- R5: Sample 10n+p (p = 0..9) is equal to floor(sum over k = 0..8 of h[10k+p]·x[n-k] / 2^15), saturated to the range -32768..32767. Here x[n] is the current symbol's amplitude and x[n-k] are earlier symbols.
- R6: The coefficients h[0..89] meet these rules: h[0..8] = 0, h[n] = h[98-n] for n = 9..89, the peak h[49] = 32767, h[9] = 850, and the values from h[9] up to h[49] follow a square-root raised cosine with roll-off 0.2 at ten samples per symbol.
- R7: The symbol history is kept across bytes and across idle cycles. Only reset clears it.
- R8: Sample index 20 of each 40-sample group (counting from 0) carries the marker that came with that byte. Every other sample carries marker 0.
- R9: A byte is accepted only when the block is idle or when the last sample of the current group is being produced. While a group is still being produced, `inReady` is low. Bytes offered back to back produce an output with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte offered |
| inData | input | 8 | Channel byte, four symbols |
| inMark | input | 2 | Marker code for this byte |
| inReady | output | 1 | Block can take a byte this cycle |
| outValid | output | 1 | Output sample valid |
| outSample | output | 16 | Signed Q15 sample |
| outMark | output | 2 | Marker for this sample (0 = none) |

## Verification
The test bytes include all-zero and all-one bytes, alternating patterns, and bytes that use all four codes in rising and in falling order. Because of this, a swapped amplitude code or a reversed symbol order shows up as a wrong sample value and not as a wrong sign only. Sending eight bytes back to back tests history carried between bytes and the gap-free handoff. A byte sent after an idle gap tests that the history is held, and a byte sent after a reset tests that the history is cleared. The markers differ from byte to byte, so a marker on the wrong sample, or the marker of the wrong byte, gives a mismatch.

// File: rtl/fsk4InterpPkg.sv
package fsk4InterpPkg;

  // control strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture new byte and marker
    logic calc;     // produce one output sample this cycle
    logic shift;    // last phase of the symbol: push it into history
    logic markSel;  // this sample carries the byte's marker
  } fsk4Strobe_t;

  localparam int PROTO_ZEROS  = 9;
  localparam int PROTO_CENTER = 49;

  // square-root raised cosine prototype, roll-off 0.2, 10 samples/symbol
  function automatic logic signed [15:0] coefAt(input int idx);
    int m;
    if (idx < PROTO_ZEROS) return 16'sd0;
    m = (idx <= PROTO_CENTER) ? idx : (2 * PROTO_CENTER - idx);
    case (m)
      9:  return 16'sd850;    10: return 16'sd592;    11: return 16'sd219;
      12: return -16'sd234;   13: return -16'sd720;   14: return -16'sd1179;
      15: return -16'sd1548;  16: return -16'sd1769;  17: return -16'sd1795;
      18: return -16'sd1597;  19: return -16'sd1172;  20: return -16'sd544;
      21: return 16'sd237;    22: return 16'sd1092;   23: return 16'sd1927;
      24: return 16'sd2637;   25: return 16'sd3120;   26: return 16'sd3286;
      27: return 16'sd3073;   28: return 16'sd2454;   29: return 16'sd1447;
      30: return 16'sd116;    31: return -16'sd1431;  32: return -16'sd3043;
      33: return -16'sd4544;  34: return -16'sd5739;  35: return -16'sd6442;
      36: return -16'sd6483;  37: return -16'sd5735;  38: return -16'sd4121;
      39: return -16'sd1633;  40: return 16'sd1669;   41: return 16'sd5651;
      42: return 16'sd10118;  43: return 16'sd14822;  44: return 16'sd19484;
      45: return 16'sd23810;  46: return 16'sd27520;  47: return 16'sd30367;
      48: return 16'sd32156;  49: return 16'sd32767;
      default: return 16'sd0;
    endcase
  endfunction

endpackage

// File: rtl/fsk4InterpCtrl.sv
module fsk4InterpCtrl
  import fsk4InterpPkg::*;
#(
  parameter int SYMS     = 4,
  parameter int INTERP   = 10,
  parameter int MARK_POS = 20,
  localparam int PH_W    = $clog2(INTERP),
  localparam int SY_W    = $clog2(SYMS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  output fsk4Strobe_t      stb,
  output logic [SY_W-1:0]  symIdx,
  output logic [PH_W-1:0]  phase
);

  logic busy;
  logic lastPhase;
  logic lastSample;
  logic accept;

  assign lastPhase  = (phase == PH_W'(INTERP - 1));
  assign lastSample = busy && lastPhase && (symIdx == SY_W'(SYMS - 1));
  assign inReady    = !busy || lastSample;
  assign accept     = inValid && inReady;

  assign stb.load    = accept;
  assign stb.calc    = busy;
  assign stb.shift   = busy && lastPhase;
  assign stb.markSel = busy && ((int'(symIdx) * INTERP + int'(phase)) == MARK_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      symIdx <= '0;
      phase  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      symIdx <= '0;
      phase  <= '0;
    end else if (busy) begin
      if (lastPhase) begin
        phase <= '0;
        if (symIdx == SY_W'(SYMS - 1)) busy <= 1'b0;
        else symIdx <= symIdx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R9
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (busy && symIdx == '0 && phase == '0));

  // R4
  run_continue_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !lastSample) |=> busy);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < INTERP);

endmodule

// File: rtl/fsk4InterpDp.sv
module fsk4InterpDp
  import fsk4InterpPkg::*;
#(
  parameter int SYMS      = 4,
  parameter int INTERP    = 10,
  parameter int TAPS      = 9,
  parameter int SAMP_W    = 16,
  parameter int MARK_W    = 2,
  parameter int LVL_OUTER = 1362,
  parameter int LVL_INNER = 454,
  localparam int PH_W     = $clog2(INTERP),
  localparam int SY_W     = $clog2(SYMS),
  localparam int BYTE_W   = 2 * SYMS,
  localparam int PROD_W   = 2 * SAMP_W,
  localparam int ACC_W    = PROD_W + $clog2(TAPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fsk4Strobe_t              stb,
  input  logic [SY_W-1:0]          symIdx,
  input  logic [PH_W-1:0]          phase,
  input  logic [BYTE_W-1:0]        inData,
  input  logic [MARK_W-1:0]        inMark,
  output logic                     outValid,
  output logic signed [SAMP_W-1:0] outSample,
  output logic [MARK_W-1:0]        outMark
);

  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (SAMP_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - 1;

  logic [BYTE_W-1:0]        byteReg;
  logic [MARK_W-1:0]        markReg;
  logic signed [SAMP_W-1:0] hist [TAPS-1];
  logic signed [SAMP_W-1:0] window [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic [1:0]               curCode;
  logic signed [SAMP_W-1:0] curLvl;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [SAMP_W-1:0] satVal;

  // most significant pair first
  assign curCode = byteReg[BYTE_W - 2 - 2 * int'(symIdx) +: 2];

  always_comb begin
    case (curCode)
      2'b11:   curLvl = SAMP_W'(LVL_OUTER);
      2'b10:   curLvl = SAMP_W'(LVL_INNER);
      2'b00:   curLvl = -SAMP_W'(LVL_INNER);
      default: curLvl = -SAMP_W'(LVL_OUTER);
    endcase
  end

  assign window[0] = curLvl;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k > 0) begin : g_hist
      assign window[k] = hist[k-1];
    end
    assign prod[k] = window[k] * coefAt(k * INTERP + int'(phase));
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + {{(ACC_W - PROD_W){prod[k][PROD_W-1]}}, prod[k]};
  end

  assign scaled = acc >>> (SAMP_W - 1);

  always_comb begin
    if (scaled > POS_LIM)      satVal = POS_LIM[SAMP_W-1:0];
    else if (scaled < NEG_LIM) satVal = NEG_LIM[SAMP_W-1:0];
    else                       satVal = scaled[SAMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteReg   <= '0;
      markReg   <= '0;
      outValid  <= 1'b0;
      outSample <= '0;
      outMark   <= '0;
      for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
    end else begin
      outValid <= stb.calc;
      if (stb.calc) begin
        outSample <= satVal;
        outMark   <= stb.markSel ? markReg : '0;
      end
      if (stb.load) begin
        byteReg <= inData;
        markReg <= inMark;
      end
      if (stb.shift) begin
        hist[0] <= curLvl;
        for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
      end
    end
  end

  // R8
  mark_none_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.markSel |=> (outMark == '0));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    stb.calc |=> outValid);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.calc |=> !outValid);

  // R7
  shift_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    stb.shift |-> stb.calc);

endmodule

// File: rtl/fsk4Interp.sv
module fsk4Interp
  import fsk4InterpPkg::*;
#(
  parameter int SYMS      = 4,
  parameter int INTERP    = 10,
  parameter int TAPS      = 9,
  parameter int SAMP_W    = 16,
  parameter int MARK_W    = 2,
  parameter int MARK_POS  = 20,
  parameter int LVL_OUTER = 1362,
  parameter int LVL_INNER = 454,
  localparam int BYTE_W   = 2 * SYMS,
  localparam int PH_W     = $clog2(INTERP),
  localparam int SY_W     = $clog2(SYMS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [BYTE_W-1:0]        inData,
  input  logic [MARK_W-1:0]        inMark,
  output logic                     inReady,
  output logic                     outValid,
  output logic signed [SAMP_W-1:0] outSample,
  output logic [MARK_W-1:0]        outMark
);

  fsk4Strobe_t     stb;
  logic [SY_W-1:0] symIdx;
  logic [PH_W-1:0] phase;

  fsk4InterpCtrl #(
    .SYMS(SYMS), .INTERP(INTERP), .MARK_POS(MARK_POS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .stb(stb), .symIdx(symIdx), .phase(phase)
  );

  fsk4InterpDp #(
    .SYMS(SYMS), .INTERP(INTERP), .TAPS(TAPS), .SAMP_W(SAMP_W),
    .MARK_W(MARK_W), .LVL_OUTER(LVL_OUTER), .LVL_INNER(LVL_INNER)
  ) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .symIdx(symIdx), .phase(phase),
    .inData(inData), .inMark(inMark), .outValid(outValid),
    .outSample(outSample), .outMark(outMark)
  );

endmodule

// File: tb/fsk4Interp_tb_top.sv
module fsk4Interp_tb_top;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic [7:0]        inData = '0;
  logic [1:0]        inMark = '0;
  logic              inReady;
  logic              outValid;
  logic signed [15:0] outSample;
  logic [1:0]        outMark;

  always #4 clk = ~clk;

  fsk4Interp dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inMark(inMark),
    .inReady(inReady), .outValid(outValid), .outSample(outSample), .outMark(outMark)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nValid = 0;
  int wr = 0, rd = 0;
  int spanA = -1, spanB = -1, spanStart = 0;
  int bytesSent = 0;
  string curReq = "R5";
  logic signed [15:0] expS [1024];
  logic [1:0]         expM [1024];
  int mHist [8];

  localparam logic [9:0] VEC [8] = '{
    {8'h00, 2'd1}, {8'hFF, 2'd2}, {8'hAA, 2'd3}, {8'h55, 2'd1},
    {8'h1B, 2'd2}, {8'hE4, 2'd3}, {8'h5F, 2'd1}, {8'h3C, 2'd2}
  };

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6: prototype coefficients from the requirement
  function automatic int bCoef(input int n);
    int m;
    int half [41] = '{850, 592, 219, -234, -720, -1179, -1548, -1769, -1795,
      -1597, -1172, -544, 237, 1092, 1927, 2637, 3120, 3286, 3073, 2454, 1447,
      116, -1431, -3043, -4544, -5739, -6442, -6483, -5735, -4121, -1633, 1669,
      5651, 10118, 14822, 19484, 23810, 27520, 30367, 32156, 32767};
    if (n < 9) return 0;
    m = (n <= 49) ? n : 98 - n;
    return half[m - 9];
  endfunction

  // R3 amplitude codes
  function automatic int bLevel(input logic [1:0] c);
    case (c)
      2'b11: return 1362;
      2'b10: return 454;
      2'b00: return -454;
      default: return -1362;
    endcase
  endfunction

  task automatic modelByte(input logic [7:0] b, input logic [1:0] m);
    for (int s = 0; s < 4; s++) begin
      int x0;
      x0 = bLevel(b[7 - 2*s -: 2]);  // R2 order
      for (int p = 0; p < 10; p++) begin
        longint acc;
        longint y;
        acc = longint'(x0) * bCoef(p);
        for (int k = 1; k < 9; k++) acc += longint'(mHist[k-1]) * bCoef(10*k + p);
        y = acc >>> 15;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        expS[wr] = 16'(y);
        expM[wr] = (s*10 + p == 20) ? m : 2'd0;
        wr++;
      end
      for (int k = 7; k > 0; k--) mHist[k] = mHist[k-1];
      mHist[0] = x0;
    end
  endtask

  // offer a byte; returns at the negedge after it was taken
  task automatic sendByte(input logic [7:0] b, input logic [1:0] m);
    modelByte(b, m);
    bytesSent++;
    inValid = 1'b1;
    inData  = b;
    inMark  = m;
    while (!inReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    inValid = 1'b0;
    while (rd != wr) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (rd == spanStart) spanA = cyc;
      if (rd == spanStart + 319) spanB = cyc;
      nValid++;
      if (rd >= wr) begin
        chk(1'b0, "R4 unexpected sample", outSample, 0);
      end else begin
        chk(outSample == expS[rd], {curReq, " R2 R3 R5 R6 sample"}, outSample, expS[rd]);
        chk(outMark == expM[rd], "R8 marker", outMark, expM[rd]);
        rd++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) mHist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    chk(outSample == 16'sd0, "R1 outSample", outSample, 0);
    chk(outMark == 2'd0, "R1 outMark", outMark, 0);

    // vector table, back to back (R9 gapless, R7 history across bytes)
    curReq = "R7";
    spanStart = rd;
    for (int i = 0; i < 8; i++) sendByte(VEC[i][9:2], VEC[i][1:0]);
    drain();
    chk(spanB - spanA == 319, "R9 gapless 320 samples", spanB - spanA, 319);
    chk(outValid == 1'b0, "R4 idle after drain", outValid, 0);

    // isolated byte after idle gap, history held (R7); busy blocks input (R9)
    curReq = "R7 gap";
    sendByte(8'h5F, 2'd3);
    inData = 8'h00;
    chk(inReady == 1'b0, "R9 busy blocks input", inReady, 0);
    drain();
    chk(outValid == 1'b0, "R4 idle", outValid, 0);

    // reset clears history (R1)
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) mHist[k] = 0;
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    curReq = "R1 history";
    sendByte(8'hC3, 2'd2);
    drain();

    chk(nValid == 40 * bytesSent, "R4 sample count", nValid, 40 * bytesSent);
    chk(rd == wr, "R4 all samples seen", rd, wr);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule